// File: doc/BRIEF.md
# Cut-Through Flit Forwarding Port

This block steers one incoming flit stream onto one of several output channels of a router, using cut-through switching. A message is a sequence of flits: an opening flit that names the destination, any number of middle flits, and a closing flit. A message may also be a single flit that opens and closes at once. Only the opening flit carries routing information. The block looks up the output channel from the destination, holds that channel for the whole message, and streams the rest of the message to it without reading the payload again.

Every flit moves in the cycle it is accepted whenever its output is ready. Flits are not buffered, reordered or copied. The surrounding router tells the block which output channels another message already holds. A head flit aimed at such a channel waits at the input until the channel is free. The block reports back which channel it currently holds.

Top module: `cutfwd_port`

## Requirements
- R1: After a synchronous active-low reset the port has no path set up: `chan_claim` is all zero, and no `out_valid` bit is set while `in_valid` is low.
- R2: A flit's kind is held in its two top bits (00 head, 01 body, 10 tail, 11 single-flit message). With no path set up, a head or single flit is steered to output `dest % NUM_OUT`, where `dest` is the low `DEST_W` payload bits.
- R3: A steered flit is presented on its output in the same cycle, with `out_flit` of that output equal to `in_flit` and `in_ready` equal to that output's `out_ready`.
- R4: With no path set up, a head or single flit whose looked-up output has its `chan_held` bit set raises no `out_valid` and sees `in_ready` low.
- R5: A head flit that is transferred sets up the path: from the next cycle on, `chan_claim` has exactly the bit of the looked-up output set.
- R6: While a path is set up, every flit goes to the held output whatever its kind or payload bits.
- R7: A transferred tail or single flit tears down any path (in the next cycle `chan_claim` is zero), and a single flit never sets one up.
- R8: With no path set up, a body or tail flit is dropped: `in_ready` is high and no `out_valid` bit is set.
- R9: While a path is set up, `chan_held` has no effect on `in_ready` or `out_valid`.
- R10: At most one `out_valid` bit is set, and an output transfer happens only together with an input transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Input flit taken this cycle |
| in_flit | input | FLIT_W | Kind in top two bits, payload below |
| out_valid | output | NUM_OUT | Per-output flit present |
| out_ready | input | NUM_OUT | Per-output flit taken |
| out_flit | output | NUM_OUT*FLIT_W | Per-output flit, output k at bits k*FLIT_W upwards |
| chan_held | input | NUM_OUT | Output already held by another message |
| chan_claim | output | NUM_OUT | Output held by this port |

## Verification
Steering, `in_ready` and the output data are combinational, so they are due in the very cycle the stimulus is driven. The bench drives just after the rising edge and compares at the falling edge of the same cycle. Path setup and teardown show up one edge later on `chan_claim`, so the reference model commits its state only at the next rising edge and compares the claim at the falling edge after it. Reset is applied at the start and once more with a path open, so R1 is checked from both states.

// File: rtl/cutfwd_pkg.sv
// Shared types for the cut-through forwarding port.
// Assumes the flit kind is always the top two bits of a flit.
package cutfwd_pkg;

    typedef enum logic [1:0] {
        FK_HEAD = 2'b00,
        FK_BODY = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    typedef enum logic {
        PS_IDLE   = 1'b0,
        PS_ROUTED = 1'b1
    } path_state_e;

    // True for kinds that carry a destination
    function automatic logic kind_opens(flit_kind_e k);
        return (k == FK_HEAD) || (k == FK_SOLO);
    endfunction

    // True for kinds that end a message
    function automatic logic kind_closes(flit_kind_e k);
        return (k == FK_TAIL) || (k == FK_SOLO);
    endfunction

endpackage

// File: rtl/cutfwd_route_lookup.sv
// Destination-to-output lookup: output = dest modulo NUM_OUT.
// Assumes PORT_W bits hold any index below NUM_OUT and PORT_W <= DEST_W.
module cutfwd_route_lookup #(
    parameter int DEST_W  = 4,
    parameter int NUM_OUT = 4,
    parameter int PORT_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic [DEST_W-1:0]  dest,
    output logic [PORT_W-1:0]  port_idx,
    output logic [NUM_OUT-1:0] port_hot
);
    localparam bit IS_POW2 = (NUM_OUT & (NUM_OUT - 1)) == 0;

    generate
        if (IS_POW2) begin : g_slice
            // Power-of-two output count: modulo is a bit slice
            assign port_idx = dest[PORT_W-1:0];
        end else begin : g_mod
            // Other output counts: a true remainder
            assign port_idx = PORT_W'(dest % DEST_W'(NUM_OUT));
        end
    endgenerate

    // One-hot form of the chosen output
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_hot
        assign port_hot[k] = (port_idx == PORT_W'(k));
    end
endmodule

// File: rtl/cutfwd_path_fsm.sv
// Path state: remembers whether a message owns an output and which one.
// Assumes 'fire' is the input handshake and 'want' is valid on head flits.
module cutfwd_path_fsm
    import cutfwd_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int PORT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  flit_kind_e         kind,
    input  logic [PORT_W-1:0]  want,
    output path_state_e        state,
    output logic [PORT_W-1:0]  sel,
    output logic [NUM_OUT-1:0] sel_hot
);
    // Sets up the path on a head flit, tears it down on the closing flit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            sel   <= '0;
        end else if (state == PS_IDLE) begin
            if (fire && kind == FK_HEAD) begin
                state <= PS_ROUTED;
                sel   <= want;
            end
        end else if (fire && kind_closes(kind)) begin
            state <= PS_IDLE;
        end
    end

    // One-hot form of the held output
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_hot
        assign sel_hot[k] = (sel == PORT_W'(k));
    end

    // R5: a transferred head opens the path on the looked-up output
    a_r5_open_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE && fire && kind == FK_HEAD)
        |=> (state == PS_ROUTED && sel == $past(want)));

    // R7: a transferred closing flit ends the path
    a_r7_close_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ROUTED && fire && kind_closes(kind)) |=> (state == PS_IDLE));

    // R7: a single flit never leaves a path behind
    a_r7_solo_no_path: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE && fire && kind == FK_SOLO) |=> (state == PS_IDLE));

    // R6: the held output does not move in the middle of a message
    a_r6_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ROUTED && !(fire && kind_closes(kind))) |=> (state == PS_ROUTED && $stable(sel)));
endmodule

// File: rtl/cutfwd_out_steer.sv
// Output steering: chooses the target output, gates valid and ready.
// Assumes at most one bit of each one-hot input is set.
module cutfwd_out_steer
    import cutfwd_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  flit_kind_e         kind,
    input  path_state_e        state,
    input  logic [NUM_OUT-1:0] sel_hot,
    input  logic [NUM_OUT-1:0] look_hot,
    input  logic [NUM_OUT-1:0] held,
    input  logic [NUM_OUT-1:0] out_ready,
    output logic [NUM_OUT-1:0] out_valid,
    output logic               in_ready
);
    logic [NUM_OUT-1:0] target;
    logic               blocked;
    logic               drop;

    // Picks the target: held output, looked-up output, or none (drop)
    always_comb begin
        target  = '0;
        blocked = 1'b0;
        drop    = 1'b0;
        if (state == PS_ROUTED) begin
            target = sel_hot;
        end else if (kind_opens(kind)) begin
            target  = look_hot;
            blocked = |(look_hot & held);
        end else begin
            drop = 1'b1;
        end
    end

    // Per-output valid gating
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_valid
        assign out_valid[k] = in_valid && !blocked && target[k];
    end

    // Ready follows the target output, or is forced high on a drop
    assign in_ready = drop || (!blocked && |(target & out_ready));

    // R10: never more than one output offered
    a_r10_one_out: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R10: an output transfer always pairs with an input transfer
    a_r10_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & out_ready)) |-> (in_valid && in_ready));

    // R4: a head aimed at a held output waits
    a_r4_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE && in_valid && kind_opens(kind) && |(look_hot & held))
        |-> (!in_ready && out_valid == '0));

    // R9: an open path ignores the other holders
    a_r9_held_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_ROUTED && in_valid) |-> (out_valid == sel_hot));

    // R8: stray middle or closing flits are swallowed
    a_r8_drop_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_IDLE && in_valid && !kind_opens(kind)) |-> (in_ready && out_valid == '0));
endmodule

// File: rtl/cutfwd_port.sv
// Cut-through forwarding port: one input flit stream to NUM_OUT channels.
// The opening flit picks the channel; later flits follow it unexamined.
// Assumes chan_held reflects other messages and never this port's own.
module cutfwd_port
    import cutfwd_pkg::*;
#(
    parameter int FLIT_BYTES = 4,
    parameter int NUM_OUT    = 4,
    parameter int DEST_W     = 4,
    parameter int FLIT_W     = 8 * FLIT_BYTES + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [FLIT_W-1:0]         in_flit,
    output logic [NUM_OUT-1:0]        out_valid,
    input  logic [NUM_OUT-1:0]        out_ready,
    output logic [NUM_OUT*FLIT_W-1:0] out_flit,
    input  logic [NUM_OUT-1:0]        chan_held,
    output logic [NUM_OUT-1:0]        chan_claim
);
    localparam int PORT_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

    flit_kind_e         kind;
    logic [PORT_W-1:0]  look_idx;
    logic [NUM_OUT-1:0] look_hot;
    path_state_e        state;
    logic [PORT_W-1:0]  sel;
    logic [NUM_OUT-1:0] sel_hot;
    logic               fire;

    assign kind = flit_kind_e'(in_flit[FLIT_W-1 -: 2]);
    assign fire = in_valid && in_ready;

    cutfwd_route_lookup #(
        .DEST_W  (DEST_W),
        .NUM_OUT (NUM_OUT),
        .PORT_W  (PORT_W)
    ) u_lookup (
        .dest     (in_flit[DEST_W-1:0]),
        .port_idx (look_idx),
        .port_hot (look_hot)
    );

    cutfwd_path_fsm #(
        .NUM_OUT (NUM_OUT),
        .PORT_W  (PORT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .kind    (kind),
        .want    (look_idx),
        .state   (state),
        .sel     (sel),
        .sel_hot (sel_hot)
    );

    cutfwd_out_steer #(
        .NUM_OUT (NUM_OUT)
    ) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .kind      (kind),
        .state     (state),
        .sel_hot   (sel_hot),
        .look_hot  (look_hot),
        .held      (chan_held),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .in_ready  (in_ready)
    );

    // Flit data fans out to every output; valid picks the live one
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_data
        assign out_flit[k*FLIT_W +: FLIT_W] = in_flit;
    end

    // Claim shows the output owned by an open path
    assign chan_claim = (state == PS_ROUTED) ? sel_hot : '0;

    // R1: reset leaves no claim
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (chan_claim == '0));

    // R5: an open path claims exactly one output
    a_r5_one_claim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_claim));
endmodule

// File: tb/tb_cutfwd_port.sv
// Bench: behavioural reference model, compared every cycle.
module tb_cutfwd_port;
    localparam int NO = 4;
    localparam int FW = 34;
    localparam int MAX_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [FW-1:0] in_flit = '0;
    logic [NO-1:0] out_valid;
    logic [NO-1:0] out_ready = '0;
    logic [NO*FW-1:0] out_flit;
    logic [NO-1:0] chan_held = '0;
    logic [NO-1:0] chan_claim;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // model state
    bit m_routed = 0;
    int m_sel = 0;
    string claim_tag = "R1";

    always #5 clk = ~clk;

    cutfwd_port dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
        .out_flit(out_flit), .chan_held(chan_held), .chan_claim(chan_claim)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive after the edge, compare at the falling edge, commit model
    task automatic step(input bit rst, input bit iv, input logic [1:0] kind,
                        input logic [31:0] pay, input logic [NO-1:0] ordy,
                        input logic [NO-1:0] held);
        int tgt;
        bit blocked;
        bit drop;
        bit fire;
        string tag;
        logic [NO-1:0] exp_ov;
        bit exp_ir;
        @(posedge clk);
        #1;
        rst_n = !rst;
        in_valid = iv;
        in_flit = {kind, pay};
        out_ready = ordy;
        chan_held = held;
        @(negedge clk);
        chk(claim_tag, "chan_claim", 64'(chan_claim), m_routed ? 64'(1 << m_sel) : 64'd0);
        tgt = 0; blocked = 0; drop = 0;
        if (m_routed) begin
            tgt = m_sel;
            tag = (held != '0) ? "R9" : "R6";
        end else if (kind == 2'b00 || kind == 2'b11) begin
            tgt = int'(pay[3:0]) % NO;
            blocked = held[tgt];
            tag = blocked ? "R4" : "R2";
        end else begin
            drop = 1;
            tag = "R8";
        end
        exp_ov = (iv && !drop && !blocked) ? NO'(1 << tgt) : '0;
        exp_ir = drop ? 1'b1 : (!blocked && ordy[tgt]);
        chk(rst ? "R1" : tag, "out_valid", 64'(out_valid), 64'(exp_ov));
        chk("R10", "out_valid count", 64'($countones(out_valid)), 64'($countones(exp_ov)));
        if (iv) chk(tag, "in_ready", 64'(in_ready), 64'(exp_ir));
        if (exp_ov != '0)
            chk("R3", "out_flit", 64'(out_flit[tgt*FW +: FW]), 64'({kind, pay}));
        fire = iv && exp_ir;
        claim_tag = "R5";
        if (rst) begin
            m_routed = 0;
            claim_tag = "R1";
        end else if (!m_routed) begin
            if (fire && kind == 2'b00) begin
                m_routed = 1;
                m_sel = tgt;
            end else if (fire && kind == 2'b11) claim_tag = "R7";
        end else if (fire && (kind == 2'b10 || kind == 2'b11)) begin
            m_routed = 0;
            claim_tag = "R7";
        end
    endtask

    function automatic logic [1:0] rnd_kind();
        int r = int'($urandom_range(0, 9));
        if (r < 3) return 2'b00;
        if (r < 7) return 2'b01;
        if (r < 9) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [NO-1:0] rnd_mask(int pct);
        logic [NO-1:0] m;
        for (int i = 0; i < NO; i++) m[i] = ($urandom_range(0, 99) < pct);
        return m;
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        #(MAX_CYC * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 0, 2'b00, 32'h0, '1, '0);
        // R2/R3/R5: head to output 2, bodies, tail (R7)
        step(0, 1, 2'b00, 32'h0000_0006, 4'b0100, '0);
        step(0, 1, 2'b01, 32'h1234_5671, 4'b0100, '0);
        step(0, 1, 2'b01, 32'hdead_bee3, 4'b0000, 4'b0100);
        step(0, 1, 2'b01, 32'hdead_bee3, 4'b0100, 4'b1111);
        step(0, 1, 2'b10, 32'h0000_0000, 4'b0100, '0);
        step(0, 0, 2'b00, 32'h0, '1, '0);
        // R4: head blocked by another holder, then released
        step(0, 1, 2'b00, 32'h0000_0001, '1, 4'b0010);
        step(0, 1, 2'b00, 32'h0000_0001, '1, 4'b0000);
        step(0, 1, 2'b10, 32'h0, '1, '0);
        // R8: stray body and tail with no path
        step(0, 1, 2'b01, 32'h5, '1, '0);
        step(0, 1, 2'b10, 32'h7, '1, '0);
        // R7: single flit never opens a path
        step(0, 1, 2'b11, 32'h3, '1, '0);
        step(0, 0, 2'b00, 32'h0, '1, '0);
        // Random traffic, with one reset in the middle (R1 from an open path)
        for (int c = 0; c < 4000; c++) begin
            bit r = (c >= 2000 && c < 2002);
            step(r, r ? 1'b0 : ($urandom_range(0, 9) < 8), rnd_kind(), $urandom,
                 rnd_mask(75), rnd_mask(25));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule